// File: doc/BRIEF.md
# Recovery Path Monitor

This block watches a host circuit after a period of injected faults and decides whether the host has recovered. Logic outside the block classifies the host's current state each cycle with three one-bit predicates: the state is safe, the state is a required waypoint, or the state is forbidden. The monitor is a deterministic, complete state machine driven only by these predicates. It declares recovery only for a path that reaches a safe state after at least one required state has been seen, and that never touches a forbidden state.

A start pulse re-arms the monitor from any state. Observation begins in the cycle after the pulse. The block then counts the cycles it observes. When recovery is first declared, that count is the elementary repair length: the length of the shortest prefix of the path that already qualifies. The count is then frozen.

To get plain "reached a fault-free state" recovery, tie the required predicate high and the forbidden predicate low.

Top module: `repair_monitor`

## Requirements
- R1: After reset, `repaired` is 0 and `repair_len` is 0. Predicates are ignored until the first `start` pulse.
- R2: A cycle with `start` high puts the monitor into observation from any state, including accepted and rejected. In the next cycle `repaired` is 0 and `repair_len` is 0. The predicates in the start cycle itself are ignored.
- R3: While observing, the monitor accepts when `pred_safe` is high in a cycle after a cycle in which `pred_req` was high, provided `pred_forb` has not been high in any observed cycle. `repaired` goes high in the cycle after that safe state is presented.
- R4: A safe state observed before any required state does not cause acceptance, and observation continues.
- R5: A forbidden state in any observed cycle rejects the path. A rejected monitor never asserts `repaired` until the next `start`. A forbidden state wins over a safe and required state presented in the same cycle.
- R6: A state that is required and safe, and not forbidden, in the same observed cycle causes acceptance in that cycle.
- R7: Once high, `repaired` stays high whatever the predicates do, until `start`.
- R8: At acceptance, `repair_len` equals the number of observed cycles, counted from the first cycle after `start` and including the accepting cycle. It does not change afterwards until `start`.
- R9: `repair_len` saturates at 2^CNT_W-1 and does not wrap.
- R10: With `pred_req` tied to 1 and `pred_forb` tied to 0, the first observed safe state causes acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Re-arm: clears the monitor and begins observation next cycle |
| pred_safe | input | 1 | Host state is in the safe set |
| pred_req | input | 1 | Host state is in the required set |
| pred_forb | input | 1 | Host state is in the forbidden set |
| repaired | output | 1 | High while the monitor is in its accepting state |
| repair_len | output | CNT_W | Observed cycle count, frozen at first acceptance |

## Verification
The assertions assume that the predicates are valid, known levels in every cycle, and that `start` may arrive at any time, including while observation is under way. They place no constraint on combinations: any mix of safe, required and forbidden is legal. The bench drives each predicate vector at the falling edge and holds it through the following rising edge. It deliberately presents conflicting combinations, such as forbidden together with safe and required, and restarts from the accepted and rejected states.

// File: rtl/repmon_pkg.sv
package repmon_pkg;

    typedef enum logic [2:0] {
        MON_IDLE   = 3'd0,
        MON_SEEK   = 3'd1,
        MON_ARMED  = 3'd2,
        MON_ACCEPT = 3'd3,
        MON_REJECT = 3'd4
    } mon_state_e;

    typedef struct packed {
        mon_state_e state;
    } fsm_regs_t;

endpackage

// File: rtl/repmon_fsm.sv
module repmon_fsm
    import repmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pred_safe,
    input  logic pred_req,
    input  logic pred_forb,
    output logic accepting,
    output logic active
);

    fsm_regs_t r_d, r_q;
    logic      seen_req;

    always_comb begin
        r_d      = r_q;
        seen_req = (r_q.state == MON_ARMED) || pred_req;
        if (start) begin
            r_d.state = MON_SEEK;
        end else begin
            case (r_q.state)
                MON_SEEK, MON_ARMED: begin
                    if (pred_forb)
                        r_d.state = MON_REJECT;
                    else if (seen_req && pred_safe)
                        r_d.state = MON_ACCEPT;
                    else if (seen_req)
                        r_d.state = MON_ARMED;
                    else
                        r_d.state = MON_SEEK;
                end
                MON_ACCEPT: r_d.state = MON_ACCEPT;
                MON_REJECT: r_d.state = MON_REJECT;
                default:    r_d.state = MON_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q.state <= MON_IDLE;
        else
            r_q <= r_d;
    end

    assign accepting = (r_q.state == MON_ACCEPT);
    assign active    = (r_q.state == MON_SEEK) || (r_q.state == MON_ARMED);

    // R5: a rejected path stays rejected until re-armed
    assert_reject_sink_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == MON_REJECT && !start) |=> (r_q.state == MON_REJECT));

    // R4: no acceptance straight from seeking without a required state
    assert_need_required_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == MON_SEEK && !pred_req && !start) |=> (r_q.state != MON_ACCEPT));

    // R5: a forbidden observation never leads to acceptance
    assert_forbid_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pred_forb && !start) |=> !accepting);

    // R1: before any start the monitor stays idle
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == MON_IDLE && !start) |=> (r_q.state == MON_IDLE));

endmodule

// File: rtl/repmon_len_counter.sv
module repmon_len_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear)
            r_d.cnt = '0;
        else if (inc && (r_q.cnt != CNT_MAX))
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q.cnt <= '0;
        else
            r_q <= r_d;
    end

    assign count = r_q.cnt;

    // R9: the counter pins at its ceiling instead of wrapping
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear && r_q.cnt == CNT_MAX) |=> (r_q.cnt == CNT_MAX));

    // R8: without an increment or clear the count holds
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clear) |=> $stable(r_q.cnt));

endmodule

// File: rtl/repair_monitor.sv
module repair_monitor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pred_safe,
    input  logic             pred_req,
    input  logic             pred_forb,
    output logic             repaired,
    output logic [CNT_W-1:0] repair_len
);

    logic accepting;
    logic active;

    repmon_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pred_safe (pred_safe),
        .pred_req  (pred_req),
        .pred_forb (pred_forb),
        .accepting (accepting),
        .active    (active)
    );

    repmon_len_counter #(.CNT_W(CNT_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (active && !start),
        .count (repair_len)
    );

    assign repaired = accepting;

    // R7: acceptance is sticky until re-armed
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (repaired && !start) |=> repaired);

    // R8: the length is frozen once accepted
    assert_len_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (repaired && !start) |=> $stable(repair_len));

    // R2: start clears both outputs on the next cycle
    assert_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!repaired && repair_len == '0));

endmodule

// File: tb/sim_repair_monitor.sv
module sim_repair_monitor;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ps = 1'b0, pr = 1'b0, pf = 1'b0;
    logic         repaired;
    logic [W-1:0] repair_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    repair_monitor #(.CNT_W(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pred_safe  (ps),
        .pred_req   (pr),
        .pred_forb  (pf),
        .repaired   (repaired),
        .repair_len (repair_len)
    );

    task automatic chk(input string tag, input logic act_rep, input logic exp_rep,
                       input int act_len, input int exp_len);
        checks++;
        if (act_rep !== exp_rep || act_len != exp_len) begin
            failures++;
            $display("FAIL %s: repaired=%0b len=%0d expected repaired=%0b len=%0d",
                     tag, act_rep, act_len, exp_rep, exp_len);
        end
    endtask

    // drive one cycle of inputs at a falling edge, return at the next falling edge
    task automatic tick(input logic st, input logic s, input logic r, input logic f);
        start = st; ps = s; pr = r; pf = f;
        @(negedge clk);
        start = 1'b0; ps = 1'b0; pr = 1'b0; pf = 1'b0;
    endtask

    task automatic t_reset_R1();
        chk("R1 reset", repaired, 1'b0, repair_len, 0);
        tick(0, 1, 1, 0);
        tick(0, 1, 1, 0);
        chk("R1 idle ignores predicates", repaired, 1'b0, repair_len, 0);
    endtask

    task automatic t_basic_R3();
        tick(1, 1, 1, 0);
        chk("R2 start cycle ignored", repaired, 1'b0, repair_len, 0);
        tick(0, 0, 0, 0);
        tick(0, 0, 1, 0);
        tick(0, 0, 0, 0);
        chk("R3 not yet safe", repaired, 1'b0, repair_len, 3);
        tick(0, 1, 0, 0);
        chk("R3 accept after required", repaired, 1'b1, repair_len, 4);
        chk("R8 length at accept", repaired, 1'b1, repair_len, 4);
    endtask

    task automatic t_sticky_R7();
        tick(0, 0, 0, 1);
        tick(0, 0, 0, 0);
        tick(0, 1, 1, 1);
        chk("R7 sticky after forbidden", repaired, 1'b1, repair_len, 4);
        chk("R8 frozen length", repaired, 1'b1, repair_len, 4);
    endtask

    task automatic t_safe_first_R4();
        tick(1, 0, 0, 0);
        tick(0, 1, 0, 0);
        chk("R2 rearm from accept", repaired, 1'b0, repair_len, 1);
        tick(0, 1, 0, 0);
        chk("R4 safe without required", repaired, 1'b0, repair_len, 2);
        tick(0, 0, 1, 0);
        tick(0, 1, 0, 0);
        chk("R4 later accept", repaired, 1'b1, repair_len, 4);
    endtask

    task automatic t_forbid_R5();
        tick(1, 0, 0, 0);
        tick(0, 0, 1, 0);
        tick(0, 1, 0, 1);
        chk("R5 forbidden rejects", repaired, 1'b0, repair_len, 2);
        tick(0, 1, 1, 0);
        tick(0, 1, 1, 0);
        chk("R5 reject is sink", repaired, 1'b0, repair_len, 2);
        tick(1, 0, 0, 0);
        tick(0, 1, 1, 1);
        chk("R5 forbidden beats safe", repaired, 1'b0, repair_len, 1);
        tick(1, 0, 0, 0);
        chk("R2 rearm from reject", repaired, 1'b0, repair_len, 0);
    endtask

    task automatic t_same_cycle_R6();
        tick(0, 0, 0, 0);
        tick(0, 1, 1, 0);
        chk("R6 required and safe together", repaired, 1'b1, repair_len, 2);
    endtask

    task automatic t_tied_R10();
        tick(1, 0, 1, 0);
        for (int i = 0; i < 5; i++) tick(0, 0, 1, 0);
        chk("R10 waiting", repaired, 1'b0, repair_len, 5);
        tick(0, 1, 1, 0);
        chk("R10 first safe accepts", repaired, 1'b1, repair_len, 6);
    endtask

    task automatic t_saturate_R9();
        tick(1, 0, 0, 0);
        for (int i = 0; i < 65540; i++) tick(0, 0, 0, 0);
        chk("R9 saturated", repaired, 1'b0, repair_len, 65535);
        tick(0, 1, 1, 0);
        chk("R9 accept at ceiling", repaired, 1'b1, repair_len, 65535);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_basic_R3();
        t_sticky_R7();
        t_safe_first_R4();
        t_forbid_R5();
        t_same_cycle_R6();
        t_tied_R10();
        t_saturate_R9();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule